// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Overlapped Translation

This block is a small data cache that starts its lookup while address translation is still in progress. The set index and the word select come only from the low twelve bits of the virtual address. Those bits are the same in the virtual and the physical address, so the cache can read the tags and the candidate word of both ways while the TLB maps the upper bits. One cycle later the TLB returns a hit strobe and a physical page number. The cache compares that page number against both stored tags at once and either returns the word or starts a line refill.

Lines are 32 bytes (eight 32-bit words), and there are 128 sets of two ways. A read miss with a valid translation fetches the whole line, word by word, through a simple memory read port. The line goes into the way that a per-set recency bit names as least recently used. Writes go through to memory at once. A write hit also updates the cached word. A write miss does not allocate a line. A request whose translation fails is answered as a fault and touches neither the arrays nor memory.

The controller is a three-state machine. **Idle** accepts a request and reads both ways. **Lookup** samples the translation and decides the outcome. **Fill** moves the eight words of a line. The transitions are:
- Idle→Lookup, on an accepted request.
- Lookup→Fill, on a read whose translation hits and whose tag matches in neither way.
- Lookup→Idle, in every other case (hit, fault or write).
- Fill→Fill, while words remain.
- Fill→Idle, when the eighth word arrives.

Top module: `vipt_cache`

## Requirements
- R1: After reset `resp_valid`, `mem_rd_req` and `mem_wr_en` are low, `req_ready` is high, every line is invalid (the first read of any address misses) and every recency bit names way 0.
- R2: The set index is `req_vaddr[11:5]` and the word select is `req_vaddr[4:2]`. Bits 31:12 of the virtual address never affect the lookup. Physical addresses are formed as `{tlb_ppn, req_vaddr[11:0]}`.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `tlb_hit` and `tlb_ppn` are sampled on the next edge. For a hit, a fault or any write, `resp_valid` is high for exactly one cycle right after that second edge. `resp_hit` and `resp_fault` are never high together.
- R4: A request hits only when `tlb_hit` is high and a valid way holds a tag equal to `tlb_ppn`. A read hit returns the selected word with `resp_hit` high.
- R5: With `tlb_hit` low, the response has `resp_fault`=1, `resp_hit`=0 and `resp_rdata`=0. There is no memory read, no memory write and no change to any cached line.
- R6: A read miss with `tlb_hit` high issues eight reads at `{ppn, index, word, 2'b00}` with word going 0 to 7. Each read is held on `mem_rd_req` until a one-cycle `mem_rd_valid`. The miss is then answered with `resp_hit`=0 and the requested word, and later reads of the line hit.
- R7: Each set has a recency bit that names the way not most recently used. The bit is updated on every hit (read or write) and on every fill, and a fill replaces the way it names.
- R8: A write hit stores `req_wdata` into the cached word. It drives `mem_wr_en` for one cycle in the Lookup cycle, at address `{ppn, index, word, 2'b00}` with `req_wdata`, and answers with `resp_hit`=1 and `resp_rdata`=0.
- R9: A write miss with `tlb_hit` high writes through to memory the same way as R8 but allocates no line. It answers with `resp_hit`=0, and a later read of that address misses.
- R10: `req_ready` is high only in Idle. A `req_valid` raised while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| tlb_hit | input | 1 | Translation valid, sampled in the Lookup cycle |
| tlb_ppn | input | 18 | Physical page number, sampled in the Lookup cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Request hit in the cache |
| resp_fault | output | 1 | Translation failed |
| resp_rdata | output | 32 | Read word (0 for writes and faults) |
| mem_rd_req | output | 1 | Refill read request, held until served |
| mem_rd_addr | output | 30 | Refill word byte address |
| mem_rd_valid | input | 1 | Refill word delivered this cycle |
| mem_rd_data | input | 32 | Refill word |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | 30 | Write-through byte address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The assertions assume two things about the inputs:
- `tlb_hit` and `tlb_ppn` are meaningful only in the Lookup cycle.
- Memory raises `mem_rd_valid` only while `mem_rd_req` is high, for a single cycle per word.

The bench drives the translation inputs only in the cycle after acceptance and forces `tlb_hit` low at all other times. Its memory model answers each word with a one-cycle pulse after a two-cycle gap, and only while a request is pending. The words it returns are a fixed function of the physical address, so every refilled word and every fill address can be predicted from the requirements.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } vipt_state_e;

    // Associativity is fixed by the single recency bit per set
    localparam int unsigned VIPT_WAYS = 2;

endpackage

// File: rtl/vipt_way.sv
// One way: valid bits, tag array and word-addressed data array,
// with a registered single-word read for the lookup stage.
module vipt_way #(
    parameter int unsigned SETS   = 128,
    parameter int unsigned WORDS  = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 18,
    localparam int unsigned IDX_W  = $clog2(SETS),
    localparam int unsigned WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup read
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_wsel,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word,
    // word write (fill or write hit)
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_wsel,
    input  logic [DATA_W-1:0] wr_data,
    // tag install at end of fill
    input  logic              tag_we,
    input  logic [IDX_W-1:0]  tag_idx,
    input  logic [TAG_W-1:0]  tag_data
);

    localparam int unsigned ENTRIES = SETS * WORDS;

    logic [DATA_W-1:0] data_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [SETS-1:0]   vld_q;

    // storage arrays carry no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[{wr_idx, wr_wsel}] <= wr_data;
        end
        if (tag_we) begin
            tag_q[tag_idx] <= tag_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (tag_we) begin
            vld_q[tag_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
            rd_word  <= '0;
        end else if (rd_en) begin
            rd_valid <= vld_q[rd_idx];
            rd_tag   <= tag_q[rd_idx];
            rd_word  <= data_q[{rd_idx, rd_wsel}];
        end
    end

endmodule

// File: rtl/vipt_tag_cmp.sv
// Parallel physical-tag compare across all ways and hit-word select.
module vipt_tag_cmp #(
    parameter int unsigned WAYS   = 2,
    parameter int unsigned TAG_W  = 18,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              tlb_hit,
    input  logic [TAG_W-1:0]  tlb_ppn,
    input  logic [WAYS-1:0]   rd_valid,
    input  logic [TAG_W-1:0]  rd_tag  [WAYS],
    input  logic [DATA_W-1:0] rd_word [WAYS],
    output logic [WAYS-1:0]   way_hit,
    output logic              any_hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] hit_word
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = tlb_hit && rd_valid[w] && (rd_tag[w] == tlb_ppn);
    end

    assign any_hit = |way_hit;

    always_comb begin
        hit_way  = '0;
        hit_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                hit_way  = WAY_W'(w);
                hit_word = rd_word[w];
            end
        end
    end

endmodule

// File: rtl/vipt_lru.sv
// Per-set recency bit for a two-way cache: names the victim way.
module vipt_lru #(
    parameter int unsigned SETS = 128,
    localparam int unsigned IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             victim,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (upd_en) begin
            lru_q[upd_idx] <= ~upd_way;
        end
    end

    assign victim = lru_q[rd_idx];

    AST_LRU_POINTS_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (lru_q[$past(upd_idx)] != $past(upd_way)));   // R7

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
#(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned PA_W       = 30,
    parameter int unsigned PAGE_BITS  = 12,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned SETS       = 128,
    parameter int unsigned DATA_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      tlb_hit,
    input  logic [PA_W-PAGE_BITS-1:0] tlb_ppn,
    output logic                      resp_valid,
    output logic                      resp_hit,
    output logic                      resp_fault,
    output logic [DATA_W-1:0]         resp_rdata,
    output logic                      mem_rd_req,
    output logic [PA_W-1:0]           mem_rd_addr,
    input  logic                      mem_rd_valid,
    input  logic [DATA_W-1:0]         mem_rd_data,
    output logic                      mem_wr_en,
    output logic [PA_W-1:0]           mem_wr_addr,
    output logic [DATA_W-1:0]         mem_wr_data
);

    localparam int unsigned WAYS     = VIPT_WAYS;
    localparam int unsigned WAY_W    = $clog2(WAYS);
    localparam int unsigned BYTE_OFF = $clog2(DATA_W / 8);
    localparam int unsigned OFF_W    = $clog2(LINE_BYTES);
    localparam int unsigned WORDS    = LINE_BYTES / (DATA_W / 8);
    localparam int unsigned WSEL_W   = $clog2(WORDS);
    localparam int unsigned IDX_W    = $clog2(SETS);
    localparam int unsigned TAG_W    = PA_W - PAGE_BITS;
    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(WORDS - 1);

    // ---------------- state and request registers ----------------
    vipt_state_e state_q, state_d;

    logic [PAGE_BITS-1:BYTE_OFF] q_poff;     // untranslated word address
    logic                        q_write;
    logic [DATA_W-1:0]           q_wdata;
    logic [TAG_W-1:0]            q_ppn;
    logic [WAY_W-1:0]            q_victim;
    logic [WSEL_W-1:0]           fill_cnt;
    logic [DATA_W-1:0]           fill_word;

    logic [IDX_W-1:0]  q_idx;
    logic [WSEL_W-1:0] q_wsel;
    assign q_idx  = q_poff[OFF_W+IDX_W-1:OFF_W];
    assign q_wsel = q_poff[OFF_W-1:BYTE_OFF];

    // bits of the virtual address this block never looks at
    logic unused_vaddr;
    assign unused_vaddr = ^{req_vaddr[VA_W-1:PAGE_BITS], req_vaddr[BYTE_OFF-1:0]};

    // ---------------- way arrays ----------------
    logic              acc;
    logic [IDX_W-1:0]  rd_idx;
    logic [WSEL_W-1:0] rd_wsel;
    logic [WAYS-1:0]   way_valid;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_word [WAYS];
    logic [WAYS-1:0]   way_we;
    logic [WAYS-1:0]   way_tag_we;
    logic [WSEL_W-1:0] wr_wsel;
    logic [DATA_W-1:0] wr_data;

    logic [WAYS-1:0]   way_hit;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [DATA_W-1:0] hit_word;
    logic              look_hit;
    logic              fill_beat;
    logic              fill_last;
    logic              lru_victim;

    assign acc       = (state_q == ST_IDLE) && req_valid;
    assign rd_idx    = req_vaddr[OFF_W+IDX_W-1:OFF_W];
    assign rd_wsel   = req_vaddr[OFF_W-1:BYTE_OFF];
    assign look_hit  = (state_q == ST_LOOKUP) && any_hit;
    assign fill_beat = (state_q == ST_FILL) && mem_rd_valid;
    assign fill_last = fill_beat && (fill_cnt == LAST_WORD);
    assign wr_wsel   = (state_q == ST_FILL) ? fill_cnt : q_wsel;
    assign wr_data   = (state_q == ST_FILL) ? mem_rd_data : q_wdata;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_we[w] = (look_hit && q_write && way_hit[w])
                        || (fill_beat && (q_victim == WAY_W'(w)));
        assign way_tag_we[w] = fill_last && (q_victim == WAY_W'(w));

        vipt_way #(
            .SETS   (SETS),
            .WORDS  (WORDS),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (acc),
            .rd_idx   (rd_idx),
            .rd_wsel  (rd_wsel),
            .rd_valid (way_valid[w]),
            .rd_tag   (way_tag[w]),
            .rd_word  (way_word[w]),
            .wr_en    (way_we[w]),
            .wr_idx   (q_idx),
            .wr_wsel  (wr_wsel),
            .wr_data  (wr_data),
            .tag_we   (way_tag_we[w]),
            .tag_idx  (q_idx),
            .tag_data (q_ppn)
        );
    end

    vipt_tag_cmp #(
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .tlb_hit  (tlb_hit),
        .tlb_ppn  (tlb_ppn),
        .rd_valid (way_valid),
        .rd_tag   (way_tag),
        .rd_word  (way_word),
        .way_hit  (way_hit),
        .any_hit  (any_hit),
        .hit_way  (hit_way),
        .hit_word (hit_word)
    );

    vipt_lru #(
        .SETS (SETS)
    ) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (q_idx),
        .victim  (lru_victim),
        .upd_en  (look_hit || fill_last),
        .upd_idx (q_idx),
        .upd_way (look_hit ? hit_way : q_victim)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (tlb_hit && !any_hit && !q_write) state_d = ST_FILL;
                else                                  state_d = ST_IDLE;
            end
            ST_FILL: begin
                if (fill_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- output and datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_poff     <= '0;
            q_write    <= 1'b0;
            q_wdata    <= '0;
            q_ppn      <= '0;
            q_victim   <= '0;
            fill_cnt   <= '0;
            fill_word  <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_poff  <= req_vaddr[PAGE_BITS-1:BYTE_OFF];
                        q_write <= req_write;
                        q_wdata <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    q_ppn    <= tlb_ppn;
                    q_victim <= lru_victim;
                    fill_cnt <= '0;
                    if (!tlb_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_fault <= 1'b1;
                        resp_rdata <= '0;
                    end else if (any_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_fault <= 1'b0;
                        resp_rdata <= q_write ? '0 : hit_word;
                    end else if (q_write) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_fault <= 1'b0;
                        resp_rdata <= '0;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        fill_cnt <= fill_cnt + 1'b1;
                        if (fill_cnt == q_wsel) fill_word <= mem_rd_data;
                        if (fill_cnt == LAST_WORD) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b0;
                            resp_fault <= 1'b0;
                            resp_rdata <= (fill_cnt == q_wsel) ? mem_rd_data : fill_word;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- memory-side and handshake outputs ----------------
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_req  = (state_q == ST_FILL);
        mem_rd_addr = {q_ppn, q_poff[PAGE_BITS-1:OFF_W], fill_cnt, {BYTE_OFF{1'b0}}};
        mem_wr_en   = (state_q == ST_LOOKUP) && q_write && tlb_hit;
        mem_wr_addr = {tlb_ppn, q_poff, {BYTE_OFF{1'b0}}};
        mem_wr_data = q_wdata;
    end

    // ---------------- assertions ----------------
    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_hit && resp_fault));   // R3

    AST_HIT_NEEDS_TLB: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> $past(tlb_hit));   // R4

    AST_FAULT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOOKUP) && !tlb_hit) |=> !mem_rd_req);   // R5

    AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid && (mem_rd_addr[OFF_W-1:BYTE_OFF] != LAST_WORD))
        |=> (mem_rd_req && (mem_rd_addr == $past(mem_rd_addr) + PA_W'(DATA_W / 8))));   // R6

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |-> ($countones(way_hit) <= 1));   // R7

endmodule

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_wdata = '0;
    logic        tlb_hit = 1'b0;
    logic [17:0] tlb_ppn = '0;
    logic        resp_valid, resp_hit, resp_fault;
    logic [31:0] resp_rdata;
    logic        mem_rd_req;
    logic [29:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        mem_wr_en;
    logic [29:0] mem_wr_addr;
    logic [31:0] mem_wr_data;

    always #4 clk = ~clk;   // 125 MHz

    vipt_cache u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_vaddr (req_vaddr), .req_wdata (req_wdata),
        .tlb_hit (tlb_hit), .tlb_ppn (tlb_ppn),
        .resp_valid (resp_valid), .resp_hit (resp_hit), .resp_fault (resp_fault),
        .resp_rdata (resp_rdata),
        .mem_rd_req (mem_rd_req), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data),
        .mem_wr_en (mem_wr_en), .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data)
    );

    function automatic logic [31:0] mem_f(input logic [29:0] pa);
        return {2'b11, pa} ^ 32'h0F0F_3C3C;
    endfunction

    // ---------------- memory model and logs ----------------
    logic [1:0]  dly;
    int          fill_n;
    logic [29:0] fill_log [16];
    int          wr_n;
    logic [29:0] wr_addr_l;
    logic [31:0] wr_data_l;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_valid <= 1'b0;
            mem_rd_data  <= '0;
            dly          <= '0;
        end else begin
            mem_rd_valid <= 1'b0;
            if (mem_rd_req && mem_rd_valid) begin
                fill_log[fill_n[3:0]] <= mem_rd_addr;
                fill_n <= fill_n + 1;
            end else if (mem_rd_req) begin
                if (dly == 2'd1) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= mem_f(mem_rd_addr);
                    dly          <= '0;
                end else begin
                    dly <= dly + 2'd1;
                end
            end
        end
        if (mem_wr_en) begin
            wr_n      <= wr_n + 1;
            wr_addr_l <= mem_wr_addr;
            wr_data_l <= mem_wr_data;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] va;
        logic [31:0] wd;
        logic        th;
        logic [17:0] ppn;
        logic        ehit;
        logic        efault;
        logic [3:0]  efill;
        logic        ewr;
        logic [31:0] lit;   // 0: expect mem_f(pa)
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0001_20AC, 32'h0, 1'b1, 18'h00123, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R6 fill A into way 0
        '{1'b0, 32'h0001_20A0, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'h0},          // R4 hit word 0
        '{1'b0, 32'h7777_70BC, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'h0},          // R2 other VPN, same page
        '{1'b0, 32'h0002_20A4, 32'h0, 1'b1, 18'h00456, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R7 B into way 1
        '{1'b0, 32'h0001_20AC, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'h0},          // R7 touch A
        '{1'b0, 32'h0003_20A8, 32'h0, 1'b1, 18'h00789, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R7 C evicts B
        '{1'b0, 32'h0001_20B0, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'h0},          // R7 A kept
        '{1'b0, 32'h0002_20A4, 32'h0, 1'b1, 18'h00456, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R7 B was evicted
        '{1'b0, 32'h0004_20A0, 32'h0, 1'b0, 18'h00123, 1'b0, 1'b1, 4'd0, 1'b0, 32'h0},          // R5 read fault
        '{1'b1, 32'h0001_20AC, 32'hDEAD_BEEF, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b1, 32'h0},  // R8 write hit
        '{1'b0, 32'h0001_20AC, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'hDEAD_BEEF},  // R8 updated word
        '{1'b1, 32'h0005_20C4, 32'h1234_5678, 1'b1, 18'h00ABC, 1'b0, 1'b0, 4'd0, 1'b1, 32'h0},  // R9 write miss
        '{1'b0, 32'h0005_20C4, 32'h0, 1'b1, 18'h00ABC, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R9 not allocated
        '{1'b1, 32'h0001_20AC, 32'hFFFF_0000, 1'b0, 18'h00123, 1'b0, 1'b1, 4'd0, 1'b0, 32'h0},  // R5 write fault
        '{1'b0, 32'h0001_20AC, 32'h0, 1'b1, 18'h00123, 1'b1, 1'b0, 4'd0, 1'b0, 32'hDEAD_BEEF},  // R5 word untouched
        '{1'b0, 32'h0000_0FFC, 32'h0, 1'b1, 18'h3FFFF, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0},          // R2 top set, last word
        '{1'b0, 32'h0000_0FFC, 32'h0, 1'b1, 18'h3FFFF, 1'b1, 1'b0, 4'd0, 1'b0, 32'h0}           // R2 top set hit
    };

    task automatic do_access(input vec_t v, input bit poke,
                             output logic g_hit, output logic g_fault, output logic [31:0] g_data,
                             output int g_fill, output int g_wr, output int g_lat,
                             output logic g_busy, output int fbase);
        int wbase;
        fbase = fill_n;
        wbase = wr_n;
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_vaddr = v.va; req_wdata = v.wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; tlb_hit = v.th; tlb_ppn = v.ppn;
        g_busy = req_ready;
        @(posedge clk);
        @(negedge clk);
        tlb_hit = 1'b0;
        g_lat = 0;
        while (!resp_valid && g_lat < 400) begin
            if (poke) begin
                req_valid = (g_lat < 3);
                req_vaddr = 32'h0000_0000;
                req_write = 1'b0;
            end
            @(negedge clk);
            g_lat++;
        end
        req_valid = 1'b0;
        g_hit = resp_hit; g_fault = resp_fault; g_data = resp_rdata;
        g_fill = fill_n - fbase;
        g_wr = wr_n - wbase;
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        logic g_hit, g_fault, g_busy;
        logic [31:0] g_data, exp_d;
        int g_fill, g_wr, g_lat, fbase;
        do_access(v, poke, g_hit, g_fault, g_data, g_fill, g_wr, g_lat, g_busy, fbase);
        if (v.wr || v.efault) exp_d = 32'h0;
        else if (v.lit != 32'h0) exp_d = v.lit;
        else exp_d = mem_f({v.ppn, v.va[11:0]});
        check("R10 ready low while busy", 64'(g_busy), 64'(0));
        check("R4 resp_hit", 64'(g_hit), 64'(v.ehit));
        check("R5 resp_fault", 64'(g_fault), 64'(v.efault));
        check("R4 resp_rdata", 64'(g_data), 64'(exp_d));
        check("R6 words fetched", 64'(g_fill), 64'(v.efill));
        if (v.efill == 4'd0) check("R3 response latency", 64'(g_lat), 64'(0));
        else begin
            for (int k = 0; k < 8; k++)
                check("R6 fill address order", 64'(fill_log[(fbase + k) & 15]),
                      64'({v.ppn, v.va[11:5], 3'(k), 2'b00}));
        end
        if (v.ewr) begin
            check("R8 write-through count", 64'(g_wr), 64'(1));
            check("R8 write-through addr", 64'(wr_addr_l), 64'({v.ppn, v.va[11:2], 2'b00}));
            check("R9 write-through data", 64'(wr_data_l), 64'(v.wd));
        end else begin
            check("R5 no memory write", 64'(g_wr), 64'(0));
        end
        @(negedge clk);
        check("R3 single-cycle resp_valid", 64'(resp_valid), 64'(0));
        check("R10 ready back in idle", 64'(req_ready), 64'(1));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        fill_n = 0;
        wr_n   = 0;
        do_reset();
        // R1 reset state at the ports
        check("R1 resp_valid", 64'(resp_valid), 64'(0));
        check("R1 req_ready", 64'(req_ready), 64'(1));
        check("R1 mem_rd_req", 64'(mem_rd_req), 64'(0));
        check("R1 mem_wr_en", 64'(mem_wr_en), 64'(0));

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: req_valid pulsed during a refill must not start a new request
        run_vec('{1'b0, 32'h0003_20A8, 32'h0, 1'b1, 18'h00789, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0}, 1'b1);
        repeat (2) @(negedge clk);
        check("R10 poke ignored, no response", 64'(resp_valid), 64'(0));
        check("R10 poke ignored, still idle", 64'(req_ready), 64'(1));

        // R1: reset clears cached lines; A was resident and must now miss
        do_reset();
        check("R1 ready after second reset", 64'(req_ready), 64'(1));
        run_vec('{1'b0, 32'h0001_20AC, 32'h0, 1'b1, 18'h00123, 1'b0, 1'b0, 4'd8, 1'b0, 32'h0}, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule